// File: doc/BRIEF.md
# RC Oscillator Frequency Trim Loop

This block closes a digital calibration loop around an on-chip RC oscillator. It runs on the RC oscillator's own clock and watches a slow reference signal. Each rising edge of the reference, after a two-flop synchroniser, ends one measurement window. The number of RC clock cycles in that window is compared with a programmable 12-bit target. An 8-bit trim code is then moved one step, or held.

The comparison uses two separate hysteresis margins, one above the target and one below it. This keeps the code from chattering once the oscillator is close to the target. An invert control swaps the stepping direction to suit oscillators whose frequency falls as the code rises. A manual override drives a programmed code to the oscillator. While it is active, the loop keeps calculating in the background.

A run control is used to hold the loop. While it is low the loop stays in reset, the reported count reads zero and the calculated code is preset to the programmed value. When it goes high, tuning starts from the programmed value.

The loop is a state machine with four states:
- `ST_IDLE`: held in reset.
- `ST_ARM`: waiting for the reference edge that opens the first window.
- `ST_MEASURE`: counting.
- `ST_UPDATE`: a single cycle in which the trim step is taken while counting continues.

The transitions are:
- IDLE to ARM when the run control is high.
- ARM to MEASURE on a reference edge.
- MEASURE to UPDATE on a reference edge.
- UPDATE back to MEASURE unconditionally.
- Any state to IDLE when the run control is low.

Top module: `rc_trim_loop`

## Requirements
- R1: While `tune_start` is low, `meas_count` reads 0, no measurement is taken and the calculated code is loaded from `manual_code` on every clock edge.
- R2: After `tune_start` rises, the first synchronised rising edge of `ref_in` only opens a window. Each later rising edge reports in `meas_count` the number of `rc_clk` cycles since the previous one. The count appears on the third rising `rc_clk` edge counting from the first edge that samples `ref_in` high, and the trim code one edge after that.
- R3: When the count is greater than `target_count + hyst_hi`, the code decrements by one if `step_invert` is 0 and increments by one if it is 1.
- R4: When the count plus `hyst_lo` is less than `target_count`, the code increments by one if `step_invert` is 0 and decrements by one if it is 1.
- R5: When the count lies in the closed band from `target_count - hyst_lo` to `target_count + hyst_hi`, the code is unchanged. Both band edges are inclusive.
- R6: The code saturates: a step down at 0x00 keeps 0x00, and a step up at 0xFF keeps 0xFF. It never wraps.
- R7: While `tune_enable` is low at the update, the code is held, but `meas_count` still updates.
- R8: While `use_manual` is high, `trim_code` equals `manual_code` in the same cycle. The calculated code keeps stepping in the background and reappears on `trim_code` as soon as `use_manual` falls.
- R9: `meas_count` saturates at 4095 for windows of 4095 or more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | RC oscillator clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| tune_start | input | 1 | Run control; low holds the loop in reset |
| tune_enable | input | 1 | Allows the trim code to step at each update |
| use_manual | input | 1 | Drives `manual_code` to the oscillator instead of the calculated code |
| step_invert | input | 1 | Swaps the stepping direction |
| manual_code | input | 8 | Programmed trim code; also the start value of the calculated code |
| target_count | input | 12 | Wanted RC cycles per reference period |
| hyst_hi | input | 4 | Margin above the target before stepping |
| hyst_lo | input | 4 | Margin below the target before stepping |
| ref_in | input | 1 | Slow reference, asynchronous to `rc_clk` |
| trim_code | output | 8 | Trim code applied to the oscillator |
| meas_count | output | 12 | Count from the last completed window |

## Verification
A new count is due three `rc_clk` edges after the first edge that samples a reference rise, and the new code one edge later. The bench drives each rise half a cycle before an edge and samples both results five falling edges later, well clear of both updates. Each reported window is checked against the period the bench itself drove. Each check compares against the result of the window just closed, computed with the controls in force at that update. Settings change only in the low phase of the reference, so no update sees a mixture of old and new controls.

// File: rtl/rc_trim_pkg.sv
`timescale 1ns/1ps
package rc_trim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2,
        ST_UPDATE  = 2'd3
    } trim_state_e;
endpackage

// File: rtl/rc_ref_sync.sv
`timescale 1ns/1ps
// Synchronises the slow reference into the RC clock domain and flags its rising edge.
module rc_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-1:0], ref_async};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/rc_window_counter.sv
`timescale 1ns/1ps
// Counts RC cycles inside a window and latches the saturated result at its close.
module rc_window_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             restart,
    input  logic             capture,
    input  logic             run,
    output logic [CNT_W-1:0] meas
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            meas <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (capture) begin
            meas <= cnt_inc;
            cnt  <= '0;
        end else if (run) begin
            cnt <= cnt_inc;
        end
    end
endmodule

// File: rtl/rc_trim_stepper.sv
`timescale 1ns/1ps
// Compares a window count with the hysteresis band and steps the code with saturation.
module rc_trim_stepper #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12,
    parameter int HYST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] load_val,
    input  logic              step,
    input  logic              invert,
    input  logic [CNT_W-1:0]  meas,
    input  logic [CNT_W-1:0]  target,
    input  logic [HYST_W-1:0] hyst_up,
    input  logic [HYST_W-1:0] hyst_dn,
    output logic [CODE_W-1:0] code
);
    localparam int          EXT_W    = CNT_W + 1;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [EXT_W-1:0]  meas_x, tgt_x, up_x, dn_x;
    logic              above, below, go_up;
    logic [CODE_W-1:0] code_nxt;

    assign meas_x = {1'b0, meas};
    assign tgt_x  = {1'b0, target};
    assign up_x   = {{(EXT_W-HYST_W){1'b0}}, hyst_up};
    assign dn_x   = {{(EXT_W-HYST_W){1'b0}}, hyst_dn};

    assign above = meas_x > (tgt_x + up_x);
    assign below = (meas_x + dn_x) < tgt_x;
    assign go_up = above ? invert : ~invert;

    always_comb begin
        code_nxt = code;
        if (above || below) begin
            if (go_up) code_nxt = (code == CODE_MAX) ? code : code + 1'b1;
            else       code_nxt = (code == '0)       ? code : code - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       code <= '0;
        else if (load) code <= load_val;
        else if (step) code <= code_nxt;
    end
endmodule

// File: rtl/rc_trim_loop.sv
`timescale 1ns/1ps
module rc_trim_loop #(
    parameter int CODE_W      = 8,
    parameter int CNT_W       = 12,
    parameter int HYST_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rc_clk,
    input  logic              rst,
    input  logic              tune_start,
    input  logic              tune_enable,
    input  logic              use_manual,
    input  logic              step_invert,
    input  logic [CODE_W-1:0] manual_code,
    input  logic [CNT_W-1:0]  target_count,
    input  logic [HYST_W-1:0] hyst_hi,
    input  logic [HYST_W-1:0] hyst_lo,
    input  logic              ref_in,
    output logic [CODE_W-1:0] trim_code,
    output logic [CNT_W-1:0]  meas_count
);
    import rc_trim_pkg::*;

    trim_state_e       state_q, state_d;
    logic              ref_rise;
    logic              ctl_clear, ctl_restart, ctl_capture, ctl_run, ctl_step;
    logic [CODE_W-1:0] calc_code;

    rc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (rc_clk),
        .rst       (rst),
        .ref_async (ref_in),
        .rise      (ref_rise)
    );

    // State register
    always_ff @(posedge rc_clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!tune_start) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_ARM;
                ST_ARM:     if (ref_rise) state_d = ST_MEASURE;
                ST_MEASURE: if (ref_rise) state_d = ST_UPDATE;
                ST_UPDATE:  state_d = ST_MEASURE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        ctl_clear   = ~tune_start;
        ctl_restart = 1'b0;
        ctl_capture = 1'b0;
        ctl_run     = 1'b0;
        ctl_step    = 1'b0;
        if (tune_start) begin
            unique case (state_q)
                ST_IDLE:    ;
                ST_ARM:     ctl_restart = ref_rise;
                ST_MEASURE: begin
                    ctl_capture = ref_rise;
                    ctl_run     = 1'b1;
                end
                ST_UPDATE: begin
                    ctl_run  = 1'b1;
                    ctl_step = tune_enable;
                end
                default:    ;
            endcase
        end
    end

    rc_window_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (rc_clk),
        .rst     (rst),
        .clear   (ctl_clear),
        .restart (ctl_restart),
        .capture (ctl_capture),
        .run     (ctl_run),
        .meas    (meas_count)
    );

    rc_trim_stepper #(.CODE_W(CODE_W), .CNT_W(CNT_W), .HYST_W(HYST_W)) u_step (
        .clk      (rc_clk),
        .rst      (rst),
        .load     (ctl_clear),
        .load_val (manual_code),
        .step     (ctl_step),
        .invert   (step_invert),
        .meas     (meas_count),
        .target   (target_count),
        .hyst_up  (hyst_hi),
        .hyst_dn  (hyst_lo),
        .code     (calc_code)
    );

    assign trim_code = use_manual ? manual_code : calc_code;
endmodule

// File: rtl/rc_trim_loop_chk.sv
`timescale 1ns/1ps
module rc_trim_loop_chk #(
    parameter int CODE_W      = 8,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input logic              rc_clk,
    input logic              rst,
    input logic              tune_start,
    input logic              tune_enable,
    input logic              use_manual,
    input logic              ref_in,
    input logic [CODE_W-1:0] trim_code,
    input logic [CNT_W-1:0]  meas_count
);
    AST_IDLE_CLEAR: assert property (@(posedge rc_clk) disable iff (rst)
        !tune_start |=> (meas_count == '0)); // R1

    AST_COUNT_AT_EDGE: assert property (@(posedge rc_clk) disable iff (rst)
        ($past(tune_start) && !$stable(meas_count))
        |-> ($past(ref_in, SYNC_STAGES+1) && !$past(ref_in, SYNC_STAGES+2))); // R2

    AST_STEP_SAT: assert property (@(posedge rc_clk) disable iff (rst)
        (tune_start && $past(tune_start) && !use_manual && !$past(use_manual))
        |-> (({1'b0, trim_code} == {1'b0, $past(trim_code)})
          || ({1'b0, trim_code} == {1'b0, $past(trim_code)} + 1'b1)
          || ({1'b0, trim_code} + 1'b1 == {1'b0, $past(trim_code)}))); // R6

    AST_HOLD_DISABLED: assert property (@(posedge rc_clk) disable iff (rst)
        (tune_start && $past(tune_start) && !$past(tune_enable)
         && !use_manual && !$past(use_manual))
        |-> (trim_code == $past(trim_code))); // R7
endmodule

bind rc_trim_loop rc_trim_loop_chk #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .rc_clk      (rc_clk),
    .rst         (rst),
    .tune_start  (tune_start),
    .tune_enable (tune_enable),
    .use_manual  (use_manual),
    .ref_in      (ref_in),
    .trim_code   (trim_code),
    .meas_count  (meas_count)
);

// File: tb/tb_rc_trim_loop.sv
`timescale 1ns/1ps
module tb_rc_trim_loop;
    logic        rc_clk = 1'b0;
    logic        rst, tune_start, tune_enable, use_manual, step_invert, ref_in;
    logic [7:0]  manual_code;
    logic [11:0] target_count;
    logic [3:0]  hyst_hi, hyst_lo;
    logic [7:0]  trim_code;
    logic [11:0] meas_count;

    int checks = 0;
    int fails  = 0;
    int m_code = 0;
    int pend_p = 0;
    bit done   = 1'b0;

    always #2.5 rc_clk = ~rc_clk;

    rc_trim_loop dut (
        .rc_clk(rc_clk), .rst(rst), .tune_start(tune_start), .tune_enable(tune_enable),
        .use_manual(use_manual), .step_invert(step_invert), .manual_code(manual_code),
        .target_count(target_count), .hyst_hi(hyst_hi), .hyst_lo(hyst_lo),
        .ref_in(ref_in), .trim_code(trim_code), .meas_count(meas_count)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Expected step from the band rules (R3, R4, R5) with saturation (R6).
    function automatic int step_model(input int code, input int cnt);
        bit up;
        if (cnt > int'(target_count) + int'(hyst_hi))      up = step_invert;
        else if (cnt + int'(hyst_lo) < int'(target_count)) up = !step_invert;
        else return code;
        if (up) return (code == 255) ? 255 : code + 1;
        return (code == 0) ? 0 : code - 1;
    endfunction

    // Oscillator model: the reference period seen in RC cycles grows with the code.
    function automatic int osc_period(input int code);
        return 100 + code;
    endfunction

    // One reference period; checks the window that ended at this rising edge.
    task automatic win(input int p_in, input string ctag, input string ktag);
        int p;
        int exp_cnt;
        ref_in = 1'b1;
        repeat (5) @(negedge rc_clk);
        if (pend_p != 0) begin
            exp_cnt = (pend_p > 4095) ? 4095 : pend_p;
            if (tune_enable) m_code = step_model(m_code, exp_cnt);
            chk(ctag, int'(meas_count), exp_cnt);
            chk(ktag, int'(trim_code), use_manual ? int'(manual_code) : m_code);
        end
        p = (p_in == 0) ? osc_period(m_code) : p_in;
        repeat (p/2 - 5) @(negedge rc_clk);
        ref_in = 1'b0;
        repeat (p - p/2) @(negedge rc_clk);
        pend_p = p;
    endtask

    task automatic restart(input int pv);
        tune_start  = 1'b0;
        manual_code = pv[7:0];
        repeat (3) @(negedge rc_clk);
        chk("R1 count cleared while stopped", int'(meas_count), 0);
        chk("R1 code preset from programmed value", int'(trim_code), pv);
        tune_start = 1'b1;
        m_code = pv;
        pend_p = 0;
        repeat (2) @(negedge rc_clk);
    endtask

    initial begin
        repeat (190000) @(posedge rc_clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tune_start = 1'b0; tune_enable = 1'b0; use_manual = 1'b0;
        step_invert = 1'b0; manual_code = 8'h5A; target_count = 12'd400;
        hyst_hi = 4'd3; hyst_lo = 4'd5; ref_in = 1'b0;
        repeat (4) @(negedge rc_clk);
        rst = 1'b0;
        @(negedge rc_clk);
        chk("R1 reset count", int'(meas_count), 0);
        chk("R1 reset code", int'(trim_code), 'h5A);

        // Reference runs while stopped: nothing is measured (R1).
        for (int i = 0; i < 2; i++) begin
            ref_in = 1'b1; repeat (50) @(negedge rc_clk);
            ref_in = 1'b0; repeat (50) @(negedge rc_clk);
        end
        chk("R1 no count while stopped", int'(meas_count), 0);

        tune_enable = 1'b1;
        restart('h5A);
        win(403, "R2 opener", "R2 opener");
        win(404, "R2 count 403", "R5 upper band edge holds");
        win(395, "R2 count 404", "R3 above band steps down");
        win(394, "R2 count 395", "R5 lower band edge holds");
        win(404, "R2 count 394", "R4 below band steps up");
        step_invert = 1'b1;
        win(394, "R2 count 404 inverted", "R3 inverted above band steps up");
        win(450, "R2 count 394 inverted", "R4 inverted below band steps down");
        tune_enable = 1'b0;
        step_invert = 1'b0;
        win(300, "R7 count still updates", "R7 disabled code held");
        win(4200, "R7 count still updates", "R7 disabled code held low count");
        win(500, "R9 count saturates at 4095", "R7 disabled code held long window");
        tune_enable = 1'b1;
        use_manual  = 1'b1;
        manual_code = 8'hC3;
        #1;
        chk("R8 manual code passes same cycle", int'(trim_code), 'hC3);
        win(500, "R2 count under manual", "R8 manual drives output");
        win(500, "R2 count under manual", "R8 manual still drives output");
        use_manual = 1'b0;
        #1;
        chk("R8 release shows calculated code", int'(trim_code), m_code);
        win(500, "R2 count after manual", "R8 background steps kept");

        // Saturation at both ends (R6).
        restart(1);
        win(500, "R2 opener", "R2 opener");
        win(500, "R2 count low end", "R6 step down reaches 0x00");
        win(500, "R2 count low end", "R6 held at 0x00 no wrap");
        restart('hFE);
        win(300, "R2 opener", "R2 opener");
        win(300, "R2 count high end", "R6 step up reaches 0xFF");
        win(300, "R2 count high end", "R6 held at 0xFF no wrap");

        // Closed-loop sweep over targets and hysteresis pairs.
        for (int t = 0; t < 3; t++) begin
            for (int h = 0; h < 3; h++) begin
                target_count = (t == 0) ? 12'd210 : (t == 1) ? 12'd228 : 12'd250;
                hyst_hi = (h == 0) ? 4'd0 : (h == 1) ? 4'd2 : 4'd15;
                hyst_lo = (h == 0) ? 4'd0 : (h == 1) ? 4'd5 : 4'd15;
                restart('h80);
                for (int w = 0; w < 30; w++) win(0, "R2 closed-loop count", "R3/R4 closed-loop code");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule